// File: doc/BRIEF.md
# Single-Wire Slave Bit Timing Engine

This block is the physical timing layer of a single-wire slave that takes its power from the line and drives the line only through an open-drain pull-down. It passes the line through a two-flop synchroniser and times every low period against a one-microsecond tick from the clock domain. A long low period counts as a host reset, and the block answers it with a delayed presence pulse. A shorter low period opens a bit slot, and the slot is either decoded as a host write or used to send one bit back.

The layer above chooses the slot type. If `tx_en_i` is high when the host's falling edge arrives, the slot is a read slot: the block takes `tx_bit_i`, pulses `tx_req_o` so that the next bit can be presented, and pulls the line low only when that bit is 0. Otherwise the block samples the line partway into the slot and reports the bit with a one-cycle strobe. Byte assembly and command handling belong to the layer above.

Top module: `sw_slave_phy`

## Requirements
- R1: After reset, `pull_low_o`, `rx_valid_o`, `reset_seen_o` and `tx_req_o` are all 0.
- R2: A synchronised low period of RST_MIN_US ticks (default 480) raises `reset_seen_o` for exactly one cycle, whatever state the block is in, including in the middle of a slot.
- R3: A low period shorter than RST_MIN_US ticks never raises `reset_seen_o`.
- R4: After a reset, the presence pulse (`pull_low_o` = 1) starts PWAIT_US ticks (default 30, always within 15 to 60 µs) after the line has returned high.
- R5: The presence pulse lasts PLEN_US ticks (default 120, always within 60 to 240 µs) and is then released.
- R6: In a write slot (`tx_en_i` = 0 at the falling edge), the line is sampled SAMPLE_US ticks (default 30) after the edge. High reads as 1 and low reads as 0. Each slot produces exactly one `rx_valid_o` pulse, and the block never pulls the line during a write slot.
- R7: In a read slot (`tx_en_i` = 1 at the falling edge), `tx_req_o` pulses once. A 0 bit holds the line low from the edge for DRIVE_US ticks (default 30). A 1 bit never pulls the line. A read slot produces no `rx_valid_o`.
- R8: A low period longer than a slot but shorter than the reset threshold is ignored after the first bit of its slot. No further slot, strobe or presence pulse follows until the line has gone high.
- R9: `pull_low_o` is never held for more than PLEN_US consecutive ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | One-cycle strobe, once per microsecond |
| line_i | input | 1 | Raw line level, asynchronous |
| tx_en_i | input | 1 | Marks the next slot as a read slot |
| tx_bit_i | input | 1 | Bit to send in a read slot |
| pull_low_o | output | 1 | Enable for the open-drain pull-down |
| rx_valid_o | output | 1 | Strobe: a write bit has been decoded |
| rx_bit_o | output | 1 | Value of the decoded write bit |
| reset_seen_o | output | 1 | Strobe: a host reset has been detected |
| tx_req_o | output | 1 | Strobe: the read bit was taken, present the next one |

## Verification
The assertions assume that the tick strobe lasts one cycle and arrives at least every few clocks. They also assume that the host starts a new slot only after the line has been high again, and that the host does not pull the line during the presence pulse. The stimulus models the line as a wired-AND of the host pull and `pull_low_o`. It ticks every fourth clock and waits out each slot before starting the next. Pulse lengths are randomised only inside bands that stay clear of the sampling point, so a write 1 stays below 9 µs and a write 0 lasts 50 µs or more, while the reset and long-pulse cases are driven directly.

// File: rtl/sw_phy_pkg.sv
package sw_phy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_WAITHI,
    ST_RSTLOW,
    ST_PWAIT,
    ST_PDRV
  } sw_state_e;
endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sw_low_timer.sv
module sw_low_timer #(
  parameter int RST_MIN_US = 480,
  parameter int CNT_W      = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic rst_det_o
);
  localparam logic [CNT_W-1:0] LIM   = CNT_W'(RST_MIN_US);
  localparam logic [CNT_W-1:0] LIM_M = CNT_W'(RST_MIN_US - 1);

  logic [CNT_W-1:0] low_cnt_q;
  logic             det_q;

  // counter saturates so one long low gives one strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      det_q     <= 1'b0;
    end else begin
      det_q <= 1'b0;
      if (line_i) begin
        low_cnt_q <= '0;
      end else if (tick_i && low_cnt_q != LIM) begin
        low_cnt_q <= low_cnt_q + 1'b1;
        if (low_cnt_q == LIM_M) det_q <= 1'b1;
      end
    end
  end

  assign rst_det_o = det_q;

  // R2
  single_reset_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_o |=> !rst_det_o);
endmodule

// File: rtl/sw_slot_ctrl.sv
module sw_slot_ctrl
  import sw_phy_pkg::*;
#(
  parameter int SAMPLE_US = 30,
  parameter int DRIVE_US  = 30,
  parameter int PWAIT_US  = 30,
  parameter int PLEN_US   = 120,
  parameter int CNT_W     = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic fall_i,
  input  logic rst_det_i,
  input  logic tx_en_i,
  input  logic tx_bit_i,
  output logic pull_low_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic tx_req_o
);
  localparam logic [CNT_W-1:0] SMP_L = CNT_W'(SAMPLE_US - 1);
  localparam logic [CNT_W-1:0] DRV_L = CNT_W'(DRIVE_US - 1);
  localparam logic [CNT_W-1:0] PW_L  = CNT_W'(PWAIT_US - 1);
  localparam logic [CNT_W-1:0] PL_L  = CNT_W'(PLEN_US - 1);

  sw_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_q, pull_q, rxv_q, rxb_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      pull_q <= 1'b0;
      rxv_q  <= 1'b0;
      rxb_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      req_q <= 1'b0;
      if (rst_det_i) begin
        st_q   <= ST_RSTLOW;
        pull_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (fall_i) begin
            st_q  <= ST_SLOT;
            cnt_q <= '0;
            rd_q  <= tx_en_i;
            if (tx_en_i) begin
              req_q  <= 1'b1;
              pull_q <= ~tx_bit_i;
            end
          end
          ST_SLOT: if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (rd_q) begin
              if (cnt_q == DRV_L) begin
                pull_q <= 1'b0;
                st_q   <= ST_WAITHI;
              end
            end else if (cnt_q == SMP_L) begin
              rxv_q <= 1'b1;
              rxb_q <= line_i;
              st_q  <= ST_WAITHI;
            end
          end
          // over-long lows park here until released
          ST_WAITHI: if (line_i) st_q <= ST_IDLE;
          ST_RSTLOW: if (line_i) begin
            st_q  <= ST_PWAIT;
            cnt_q <= '0;
          end
          ST_PWAIT: if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == PW_L) begin
              pull_q <= 1'b1;
              cnt_q  <= '0;
              st_q   <= ST_PDRV;
            end
          end
          ST_PDRV: if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == PL_L) begin
              pull_q <= 1'b0;
              st_q   <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign pull_low_o = pull_q;
  assign rx_valid_o = rxv_q;
  assign rx_bit_o   = rxb_q;
  assign tx_req_o   = req_q;

  // R2
  reset_preempts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_i |=> (st_q == ST_RSTLOW && !pull_low_o));
  // R6
  rx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R6
  write_no_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLOT && !rd_q) |-> !pull_low_o);
  // R7
  tx_req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o);
  // R8
  long_low_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAITHI && !line_i && !rst_det_i) |=> (!rx_valid_o && !tx_req_o && !pull_low_o));

  logic [CNT_W:0] pull_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pull_run_q <= '0;
    else if (!pull_q)     pull_run_q <= '0;
    else if (tick_i)      pull_run_q <= pull_run_q + 1'b1;
  end
  // R9
  pull_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_run_q <= (CNT_W+1)'(PLEN_US));
endmodule

// File: rtl/sw_slave_phy.sv
module sw_slave_phy #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_MIN_US  = 480,
  parameter int SAMPLE_US   = 30,
  parameter int DRIVE_US    = 30,
  parameter int PWAIT_US    = 30,
  parameter int PLEN_US     = 120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_us_i,
  input  logic line_i,
  input  logic tx_en_i,
  input  logic tx_bit_i,
  output logic pull_low_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic reset_seen_o,
  output logic tx_req_o
);
  localparam int CNT_W = $clog2(RST_MIN_US + 1);

  logic line_s, fall_s, rst_det;

  sw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  sw_low_timer #(.RST_MIN_US(RST_MIN_US), .CNT_W(CNT_W)) u_low (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_us_i),
    .line_i    (line_s),
    .rst_det_o (rst_det)
  );

  sw_slot_ctrl #(
    .SAMPLE_US (SAMPLE_US),
    .DRIVE_US  (DRIVE_US),
    .PWAIT_US  (PWAIT_US),
    .PLEN_US   (PLEN_US),
    .CNT_W     (CNT_W)
  ) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_us_i),
    .line_i     (line_s),
    .fall_i     (fall_s),
    .rst_det_i  (rst_det),
    .tx_en_i    (tx_en_i),
    .tx_bit_i   (tx_bit_i),
    .pull_low_o (pull_low_o),
    .rx_valid_o (rx_valid_o),
    .rx_bit_o   (rx_bit_o),
    .tx_req_o   (tx_req_o)
  );

  assign reset_seen_o = rst_det;
endmodule

// File: tb/sw_slave_phy_bench.sv
module sw_slave_phy_bench;
  localparam int CPU = 4; // clocks per microsecond tick

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic host_low = 1'b0, tx_en = 1'b0, tx_bit = 1'b1;
  logic pull_low, rx_valid, rx_bit, reset_seen, tx_req;
  wire  line = ~(host_low | pull_low);

  int checks = 0, fails = 0;
  int rx_cnt = 0, rst_cnt = 0, req_cnt = 0, pull_cyc = 0, div = 0;
  bit last_rx = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  sw_slave_phy u_sw_slave_phy (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .line_i(line),
    .tx_en_i(tx_en), .tx_bit_i(tx_bit), .pull_low_o(pull_low),
    .rx_valid_o(rx_valid), .rx_bit_o(rx_bit), .reset_seen_o(reset_seen),
    .tx_req_o(tx_req)
  );

  always @(negedge clk) begin
    div  <= (div == CPU-1) ? 0 : div + 1;
    tick <= (div == CPU-1);
    if (rst_n) begin
      if (rx_valid) begin rx_cnt <= rx_cnt + 1; last_rx <= rx_bit; end
      if (reset_seen) rst_cnt <= rst_cnt + 1;
      if (tx_req) req_cnt <= req_cnt + 1;
      if (pull_low) pull_cyc <= pull_cyc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (n*CPU) @(negedge clk);
  endtask

  function automatic bit in_band(input int v, input int lo, input int hi);
    return v >= lo && v <= hi;
  endfunction

  // hold low for len_us, release, then measure the presence reply
  task automatic host_reset(input int len_us, input string tag);
    int r0, dly, wid;
    r0 = rst_cnt;
    host_low = 1'b1;
    wait_us(len_us);
    host_low = 1'b0;
    dly = 0;
    while (!pull_low && dly < 400*CPU) begin @(negedge clk); dly++; end
    wid = 0;
    while (pull_low && wid < 400*CPU) begin @(negedge clk); wid++; end
    chk(rst_cnt - r0 == 1, {tag, " R2 reset strobe count"}, rst_cnt - r0, 1);
    chk(in_band(dly/CPU, 15, 60), "R4 presence delay us", dly/CPU, 30);
    chk(in_band(wid/CPU, 60, 240), "R5 presence width us", wid/CPU, 120);
    wait_us(20);
  endtask

  task automatic write_slot(input bit b);
    int r0, p0, low;
    r0 = rx_cnt; p0 = pull_cyc;
    tx_en = 1'b0;
    low = b ? 3 + int'($urandom % 6) : 50 + int'($urandom % 16);
    host_low = 1'b1;
    wait_us(low);
    host_low = 1'b0;
    wait_us(85 - low);
    chk(rx_cnt - r0 == 1, "R6 one strobe per write slot", rx_cnt - r0, 1);
    chk(last_rx == b, "R6 decoded bit", int'(last_rx), int'(b));
    chk(pull_cyc == p0, "R6 no pull in write slot", pull_cyc - p0, 0);
  endtask

  task automatic read_slot(input bit b);
    int r0, q0;
    r0 = rx_cnt; q0 = req_cnt;
    tx_en = 1'b1; tx_bit = b;
    host_low = 1'b1;
    wait_us(2);
    host_low = 1'b0;
    wait_us(13);
    chk(line == b, "R7 line level mid read slot", int'(line), int'(b));
    wait_us(35);
    chk(line == 1'b1, "R7 line released after drive", int'(line), 1);
    wait_us(20);
    chk(req_cnt - q0 == 1, "R7 one tx request", req_cnt - q0, 1);
    chk(rx_cnt == r0, "R7 no rx strobe in read slot", rx_cnt - r0, 0);
    tx_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20231));
    repeat (5) @(negedge clk);
    chk(!pull_low && !rx_valid && !reset_seen && !tx_req, "R1 outputs in reset",
        int'({pull_low, rx_valid, reset_seen, tx_req}), 0);
    rst_n = 1'b1;
    wait_us(10);
    chk(!pull_low && rx_cnt == 0 && rst_cnt == 0, "R1 idle after reset", pull_cyc, 0);

    host_reset(500, "idle");

    begin : long_low
      int r0, s0, p0;
      r0 = rx_cnt; s0 = rst_cnt; p0 = pull_cyc;
      host_low = 1'b1;
      wait_us(400);
      host_low = 1'b0;
      wait_us(150);
      chk(rst_cnt == s0, "R3 no reset for 400us low", rst_cnt - s0, 0);
      chk(rx_cnt - r0 == 1, "R8 single bit for over-long low", rx_cnt - r0, 1);
      chk(last_rx == 1'b0, "R8 over-long low reads 0", int'(last_rx), 0);
      chk(pull_cyc == p0, "R8 no presence after long low", pull_cyc - p0, 0);
    end
    write_slot(1'b1);

    for (int i = 0; i < 40; i++) write_slot(1'($urandom));
    for (int i = 0; i < 40; i++) read_slot(1'($urandom));
    write_slot(1'b0);
    read_slot(1'b0);
    read_slot(1'b1);

    // reset arriving in the middle of a read-0 slot
    tx_en = 1'b1; tx_bit = 1'b0;
    host_reset(520, "mid-slot");
    tx_en = 1'b0;
    write_slot(1'b1);
    write_slot(1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule